// File: doc/BRIEF.md
# Dual-Processor Doorbell Signaling Controller

This block lets two processors notify each other across a parameterised set of bidirectional channels (six by default). Each channel consists of two one-way subchannels, one carrying notifications from processor 1 to processor 2 and one carrying them the other way. Every subchannel has a single flag that is either occupied or free. Only the sender can make the flag occupied, and only the receiver can make it free again. Message payloads sit in a shared memory outside this block. The block only carries the "message posted" and "message consumed" events.

Each processor has a private register bank on a simple synchronous register port. Through that port it posts doorbells on its outgoing subchannels and acknowledges doorbells on its incoming subchannels. It can also read the state of both directions and program per-channel interrupt masks. Each processor receives two level interrupts. The receive line tells it that an incoming subchannel is occupied. The transmit line tells it that an outgoing subchannel is free. Both lines are ORed over all channels whose mask bit lets them through.

Top module: `doorbell_ctrl`

## Requirements
- R1: After reset, every subchannel flag is free and every mask bit is 1 (masked). As a result, all four interrupt outputs are low, a status read returns 0 and a mask read returns all ones.
- R2: A write to address 0 (post) sets bit i of the writer's outgoing flags wherever wdata bit i (i < NUM_CH) is 1. Zero bits leave the flags unchanged.
- R3: A write to address 1 (acknowledge) frees bit i of the writer's incoming flags wherever wdata bit i is 1. Zero bits leave the flags unchanged.
- R4: A processor cannot free its own outgoing flags or occupy its incoming flags. An acknowledge write leaves the writer's outgoing flags untouched, and a post write leaves its incoming flags untouched.
- R5: If, in the same cycle, the sender posts a channel and the receiver acknowledges the same subchannel, the flag ends up occupied.
- R6: A read of address 2 (status) returns the writer's outgoing flags in bits [NUM_CH-1:0] and its incoming flags in bits [2*NUM_CH-1:NUM_CH]. The value is the one held at the clock edge of the request and appears on rdata one cycle after the request.
- R7: A read of address 3 (mask) returns the mask register one cycle later. Occupied-mask bits are in [NUM_CH-1:0] and free-mask bits are in [2*NUM_CH-1:NUM_CH]. A mask write takes effect at the request edge. Reads of addresses 0 and 1 return 0.
- R8: The receive interrupt of a processor is high exactly when some channel has an occupied incoming flag and its occupied-mask bit is 0.
- R9: The transmit interrupt of a processor is high exactly when some channel has a free outgoing flag and its free-mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p1_req | input | 1 | Processor 1 register access strobe |
| p1_we | input | 1 | Processor 1 write enable (0 = read) |
| p1_addr | input | 2 | Processor 1 register select |
| p1_wdata | input | 2*NUM_CH | Processor 1 write data |
| p1_rdata | output | 2*NUM_CH | Processor 1 read data, one cycle after request |
| p1_rx_irq | output | 1 | Processor 1 incoming-occupied interrupt |
| p1_tx_irq | output | 1 | Processor 1 outgoing-free interrupt |
| p2_req | input | 1 | Processor 2 register access strobe |
| p2_we | input | 1 | Processor 2 write enable (0 = read) |
| p2_addr | input | 2 | Processor 2 register select |
| p2_wdata | input | 2*NUM_CH | Processor 2 write data |
| p2_rdata | output | 2*NUM_CH | Processor 2 read data, one cycle after request |
| p2_rx_irq | output | 1 | Processor 2 incoming-occupied interrupt |
| p2_tx_irq | output | 1 | Processor 2 outgoing-free interrupt |

## Verification
The flags are driven with several patterns, and each one separates a different kind of fault:
- **Multi-bit posts.** These show whether each channel bit lands in the right flag.
- **All-zero posts and acknowledges.** These expose write-zero side effects.
- **All-ones acknowledges from the sender.** These show whether a processor can wrongly free its own outgoing flags.
- **Same-cycle post and acknowledge from both ports.** This exposes the wrong priority.

The interrupts are checked after every operation with mask patterns that are all masked, unmask a single channel and unmask channels whose flags differ. This distinguishes a wrong mask polarity, a wrong mask half and a wrong flag direction feeding the OR. Status reads from both ports confirm that the two views of each subchannel agree.

// File: rtl/db_pkg.sv
// Package: shared register addresses for the doorbell controller.
// Assumes a 2-bit register select on each processor port.
package db_pkg;
    typedef enum logic [1:0] {
        RA_POST = 2'd0,   // write-one-to-set outgoing flags
        RA_ACK  = 2'd1,   // write-one-to-clear incoming flags
        RA_STAT = 2'd2,   // read-only {incoming, outgoing}
        RA_MASK = 2'd3    // {free mask, occupied mask}
    } reg_addr_e;
endpackage

// File: rtl/db_flag_array.sv
// Module: one direction of subchannel flags (sender -> receiver).
// Each flag is set only by the sender's set vector and freed only by the
// receiver's clear vector; a set in the same cycle as a clear wins.
// Assumes set/clear vectors are single-cycle strobes from the banks.
module db_flag_array #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] flag_o
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
        // Purpose: hold one subchannel flag, set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end
    end

    // R2: a posted bit is occupied the next cycle
    a_r2_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));
    // R3: an acknowledged bit without a concurrent post is free next cycle
    a_r3_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));
    // R4: flags move only on a strobe
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flag_o));
    // R5: post and acknowledge together leave the flag occupied
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((flag_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));
endmodule

// File: rtl/db_reg_bank.sv
// Module: one processor's private register bank.
// Decodes post/acknowledge writes into strobes, holds the interrupt masks
// and returns registered read data one cycle after the request.
// Assumes req is a single-cycle strobe; writes and reads share the port.
module db_reg_bank
    import db_pkg::*;
#(
    parameter int NUM_CH = 6,
    localparam int REG_W = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [NUM_CH-1:0] out_flags_i,
    input  logic [NUM_CH-1:0] in_flags_i,
    output logic [NUM_CH-1:0] set_o,
    output logic [NUM_CH-1:0] clr_o,
    output logic [NUM_CH-1:0] occ_mask_o,
    output logic [NUM_CH-1:0] free_mask_o
);
    reg_addr_e  sel;
    logic       wr_en;
    logic       rd_en;
    logic [REG_W-1:0] mask_q;

    assign sel   = reg_addr_e'(addr_i);
    assign wr_en = req_i && we_i;
    assign rd_en = req_i && !we_i;

    // Purpose: decode write strobes for the flag arrays.
    always_comb begin
        set_o = '0;
        clr_o = '0;
        if (wr_en && sel == RA_POST) set_o = wdata_i[NUM_CH-1:0];
        if (wr_en && sel == RA_ACK)  clr_o = wdata_i[NUM_CH-1:0];
    end

    // Purpose: hold the mask register, all masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       mask_q <= '1;
        else if (wr_en && sel == RA_MASK) mask_q <= wdata_i;
    end

    assign occ_mask_o  = mask_q[NUM_CH-1:0];
    assign free_mask_o = mask_q[REG_W-1:NUM_CH];

    // Purpose: register read data one cycle after a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en) begin
            unique case (sel)
                RA_STAT: rdata_o <= {in_flags_i, out_flags_i};
                RA_MASK: rdata_o <= mask_q;
                default: rdata_o <= '0;
            endcase
        end
    end

    // R6: status read returns the flags seen at the request edge
    a_r6_stat_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == RA_STAT) |=> (rdata_o == {$past(in_flags_i), $past(out_flags_i)}));
    // R7: a mask write is visible on the mask outputs next cycle
    a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RA_MASK) |=> ({free_mask_o, occ_mask_o} == $past(wdata_i)));
endmodule

// File: rtl/db_irq_agg.sv
// Module: aggregates one processor's per-channel conditions into its two
// level interrupts. A mask bit of 1 blocks that channel.
// Assumes flags and masks come from registers (output is combinational).
module db_irq_agg #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] in_flags_i,
    input  logic [NUM_CH-1:0] out_flags_i,
    input  logic [NUM_CH-1:0] occ_mask_i,
    input  logic [NUM_CH-1:0] free_mask_i,
    output logic              rx_irq_o,
    output logic              tx_irq_o
);
    logic [NUM_CH-1:0] rx_hit;
    logic [NUM_CH-1:0] tx_hit;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign rx_hit[i] = in_flags_i[i] && !occ_mask_i[i];
        assign tx_hit[i] = !out_flags_i[i] && !free_mask_i[i];
    end

    assign rx_irq_o = |rx_hit;
    assign tx_irq_o = |tx_hit;
endmodule

// File: rtl/doorbell_ctrl.sv
// Module: top of the dual-processor doorbell controller.
// Two flag arrays (one per direction), two private register banks and two
// interrupt aggregators. Processor 1 sends on flags_12 and receives on
// flags_21; processor 2 the reverse.
// Assumes both processors share clk and the synchronous active-low reset.
module doorbell_ctrl #(
    parameter int NUM_CH = 6,
    localparam int REG_W = 2 * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             p1_req,
    input  logic             p1_we,
    input  logic [1:0]       p1_addr,
    input  logic [REG_W-1:0] p1_wdata,
    output logic [REG_W-1:0] p1_rdata,
    output logic             p1_rx_irq,
    output logic             p1_tx_irq,
    input  logic             p2_req,
    input  logic             p2_we,
    input  logic [1:0]       p2_addr,
    input  logic [REG_W-1:0] p2_wdata,
    output logic [REG_W-1:0] p2_rdata,
    output logic             p2_rx_irq,
    output logic             p2_tx_irq
);
    logic [NUM_CH-1:0] flags_12, flags_21;
    logic [NUM_CH-1:0] p1_set, p1_clr, p2_set, p2_clr;
    logic [NUM_CH-1:0] p1_occ_m, p1_free_m, p2_occ_m, p2_free_m;

    db_flag_array #(.NUM_CH(NUM_CH)) u_flags_12 (
        .clk(clk), .rst_n(rst_n), .set_i(p1_set), .clr_i(p2_clr), .flag_o(flags_12));
    db_flag_array #(.NUM_CH(NUM_CH)) u_flags_21 (
        .clk(clk), .rst_n(rst_n), .set_i(p2_set), .clr_i(p1_clr), .flag_o(flags_21));

    db_reg_bank #(.NUM_CH(NUM_CH)) u_bank_1 (
        .clk(clk), .rst_n(rst_n), .req_i(p1_req), .we_i(p1_we), .addr_i(p1_addr),
        .wdata_i(p1_wdata), .rdata_o(p1_rdata), .out_flags_i(flags_12),
        .in_flags_i(flags_21), .set_o(p1_set), .clr_o(p1_clr),
        .occ_mask_o(p1_occ_m), .free_mask_o(p1_free_m));
    db_reg_bank #(.NUM_CH(NUM_CH)) u_bank_2 (
        .clk(clk), .rst_n(rst_n), .req_i(p2_req), .we_i(p2_we), .addr_i(p2_addr),
        .wdata_i(p2_wdata), .rdata_o(p2_rdata), .out_flags_i(flags_21),
        .in_flags_i(flags_12), .set_o(p2_set), .clr_o(p2_clr),
        .occ_mask_o(p2_occ_m), .free_mask_o(p2_free_m));

    db_irq_agg #(.NUM_CH(NUM_CH)) u_irq_1 (
        .in_flags_i(flags_21), .out_flags_i(flags_12), .occ_mask_i(p1_occ_m),
        .free_mask_i(p1_free_m), .rx_irq_o(p1_rx_irq), .tx_irq_o(p1_tx_irq));
    db_irq_agg #(.NUM_CH(NUM_CH)) u_irq_2 (
        .in_flags_i(flags_12), .out_flags_i(flags_21), .occ_mask_i(p2_occ_m),
        .free_mask_i(p2_free_m), .rx_irq_o(p2_rx_irq), .tx_irq_o(p2_tx_irq));

    // R8: a fully masked processor never sees a receive interrupt
    a_r8_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&p1_occ_m) |-> !p1_rx_irq);
    // R8: receive interrupt needs an occupied incoming flag
    a_r8_rx_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_12 == '0) |-> !p2_rx_irq);
    // R9: a fully masked processor never sees a transmit interrupt
    a_r9_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&p2_free_m) |-> !p2_tx_irq);
    // R9: transmit interrupt needs a free outgoing flag
    a_r9_tx_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        (&flags_12) |-> !p1_tx_irq);
endmodule

// File: tb/tb_doorbell_ctrl.sv
// Scoreboard bench: the driver task pushes expected read data into a queue,
// and a monitor pops and compares it when rdata is valid.
module tb_doorbell_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int W = 2 * NCH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p1_req = 0, p1_we = 0, p2_req = 0, p2_we = 0;
    logic [1:0] p1_addr = 0, p2_addr = 0;
    logic [W-1:0] p1_wdata = 0, p2_wdata = 0;
    logic [W-1:0] p1_rdata, p2_rdata;
    logic p1_rx_irq, p1_tx_irq, p2_rx_irq, p2_tx_irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model state
    logic [NCH-1:0] m12 = '0, m21 = '0;
    logic [W-1:0]   mk1 = '1, mk2 = '1;

    // Scoreboard queues
    logic [W-1:0] q_exp[$];
    int           q_port[$];
    string        q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    doorbell_ctrl #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n),
        .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
        .p1_rdata(p1_rdata), .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq),
        .p2_req(p2_req), .p2_we(p2_we), .p2_addr(p2_addr), .p2_wdata(p2_wdata),
        .p2_rdata(p2_rdata), .p2_rx_irq(p2_rx_irq), .p2_tx_irq(p2_tx_irq));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_read(input int p, input logic [1:0] a);
        case (a)
            2'd2:    return (p == 1) ? {m21, m12} : {m12, m21};
            2'd3:    return (p == 1) ? mk1 : mk2;
            default: return '0;
        endcase
    endfunction

    // Monitor: compare read data one cycle after each request
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            automatic logic [W-1:0] e = q_exp.pop_front();
            automatic int p = q_port.pop_front();
            automatic string t = q_tag.pop_front();
            check(t, (p == 1) ? p1_rdata : p2_rdata, e);
        end
    end

    // Driver: one bus cycle on both ports, then update the model
    task automatic cyc(input bit r1, input bit w1, input logic [1:0] a1, input logic [W-1:0] d1,
                       input bit r2, input bit w2, input logic [1:0] a2, input logic [W-1:0] d2,
                       input string tag);
        logic [W-1:0] e1, e2;
        logic [NCH-1:0] s1, c1, s2, c2;
        @(negedge clk);
        p1_req = r1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
        p2_req = r2; p2_we = w2; p2_addr = a2; p2_wdata = d2;
        e1 = exp_read(1, a1);
        e2 = exp_read(2, a2);
        s1 = (r1 && w1 && a1 == 2'd0) ? d1[NCH-1:0] : '0;
        c1 = (r1 && w1 && a1 == 2'd1) ? d1[NCH-1:0] : '0;
        s2 = (r2 && w2 && a2 == 2'd0) ? d2[NCH-1:0] : '0;
        c2 = (r2 && w2 && a2 == 2'd1) ? d2[NCH-1:0] : '0;
        @(posedge clk);
        #1;
        m12 = (m12 & ~c2) | s1;
        m21 = (m21 & ~c1) | s2;
        if (r1 && w1 && a1 == 2'd3) mk1 = d1;
        if (r2 && w2 && a2 == 2'd3) mk2 = d2;
        if (r1 && !w1) begin q_exp.push_back(e1); q_port.push_back(1); q_tag.push_back({tag, " p1 read"}); end
        if (r2 && !w2) begin q_exp.push_back(e2); q_port.push_back(2); q_tag.push_back({tag, " p2 read"}); end
        p1_req = 0; p2_req = 0;
    endtask

    task automatic w1(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        cyc(1, 1, a, d, 0, 0, 0, 0, tag);
    endtask
    task automatic w2(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        cyc(0, 0, 0, 0, 1, 1, a, d, tag);
    endtask

    // Read status on both ports, then check all four interrupts
    task automatic snap(input string tag);
        cyc(1, 0, 2'd2, '0, 1, 0, 2'd2, '0, tag);
        @(negedge clk);
        check({tag, " R8 p1_rx"}, W'(p1_rx_irq), W'(|(m21 & ~mk1[NCH-1:0])));
        check({tag, " R8 p2_rx"}, W'(p2_rx_irq), W'(|(m12 & ~mk2[NCH-1:0])));
        check({tag, " R9 p1_tx"}, W'(p1_tx_irq), W'(|(~m12 & ~mk1[W-1:NCH])));
        check({tag, " R9 p2_tx"}, W'(p2_tx_irq), W'(|(~m21 & ~mk2[W-1:NCH])));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        snap("R1 reset");
        cyc(1, 0, 2'd3, '0, 1, 0, 2'd3, '0, "R1 mask reset");
        // R2: post two channels from p1
        w1(2'd0, W'(6'b000101), "R2 post");
        snap("R2 after post");
        // R8: unmask occupied ch0 at p2
        w2(2'd3, ~W'(1), "R8 unmask");
        snap("R8 unmasked");
        // R2: zeros have no effect
        w1(2'd0, '0, "R2 zero post");
        snap("R2 zero post");
        // R4: p1 acknowledge cannot free its own outgoing flags
        w1(2'd1, W'(6'h3F), "R4 wrong dir ack");
        snap("R4 wrong dir ack");
        // R4: p2 post lands in p2->p1 only
        w2(2'd0, W'(6'b010010), "R4 p2 post");
        snap("R4 p2 post");
        // R3: p2 acknowledges ch0
        w2(2'd1, W'(1), "R3 ack");
        snap("R3 ack");
        // R3: zero acknowledge
        w2(2'd1, '0, "R3 zero ack");
        snap("R3 zero ack");
        // R9: unmask free ch0 at p1, then re-occupy it
        w1(2'd3, ~(W'(1) << NCH), "R9 unmask");
        snap("R9 free unmasked");
        w1(2'd0, W'(1), "R9 repost");
        snap("R9 reposted");
        // R8: p1 unmasks ch1 and ch4 (p2->p1 occupied)
        w1(2'd3, ~(W'(1) << NCH) & ~W'(6'b010010), "R8 p1 unmask");
        snap("R8 p1 unmasked");
        // R5: same-cycle post (p1 ch3) and acknowledge (p2 ch3)
        w1(2'd0, W'(6'b001000), "R5 prep");
        cyc(1, 1, 2'd0, W'(6'b001000), 1, 1, 2'd1, W'(6'b001000), "R5 race");
        snap("R5 set wins");
        // R5: race on fresh free channel ch5 and p2 ack of ch2 together
        cyc(1, 1, 2'd0, W'(6'b100000), 1, 1, 2'd1, W'(6'b100100), "R5 race2");
        snap("R5 race2");
        // R9: p2 unmasks free on all channels
        w2(2'd3, {{NCH{1'b0}}, ~NCH'(1)}, "R9 p2 unmask");
        snap("R9 p2 free");
        // R7: mask reads and post/ack address reads
        cyc(1, 0, 2'd3, '0, 1, 0, 2'd3, '0, "R7 mask read");
        cyc(1, 0, 2'd0, '0, 1, 0, 2'd1, '0, "R7 post/ack read zero");
        // R6: p1 acknowledges everything incoming
        w1(2'd1, W'(6'h3F), "R6 ack all");
        snap("R6 final");
        cyc(0, 0, 0, '0, 0, 0, 0, '0, "flush");
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule